// File: doc/BRIEF.md
# Segment Register Load and Access Checker

This block guards the loading of a segment register and every later memory access made through it. A load request carries a 16-bit selector, the current privilege level and the kind of register being loaded (data or stack). The block splits the selector into its fields and checks the entry against the bound of the chosen descriptor table. When a descriptor is needed, it fetches the 64-bit descriptor over a one-outstanding request/valid port. It then applies the presence, type and privilege rules and reports either success or a fault code. A successful load stores the segment base and the expanded byte limit in a cache register.

Each access request gives an offset, a length of one to four bytes and a read/write flag. The block checks it against the cached segment and, one cycle later, returns either the linear address or a fault. A successful write also raises a strobe, so that the surrounding logic can set the descriptor's accessed flag. Fault codes are 0 none, 1 general protection (GP), 2 segment not present (NP) and 3 stack fault (SS).

Top module: `seg_load_checker`

## Requirements
- R1: Selector bits 1:0 are the requested level, bit 2 picks the table (0 global, 1 local) and bits 15:3 are the entry index. A fetch drives memTable with bit 2 and memOffset with index*8, and both stay stable while the request waits.
- R2: If index*8+7 exceeds the chosen table limit (gdtLimit or ldtLimit), the load ends with GP and no fetch is made. loadDone is then visible two cycles after the request cycle.
- R3: memReq stays high until memValid is seen. loadDone is high for exactly one cycle, in the cycle after memValid, and memReq is low by then.
- R4: When descriptor bit 47 (present) is clear, the load faults with NP for a data register and SS for a stack register, whatever the other descriptor bits hold. loadOk is high exactly when loadFault is 0.
- R5: For a data register, the effective level is the larger of the CPL and the requested level. The load succeeds only if DPL (bits 46:45) is at least that level, bit 44 is set (code or data) and, for code (bit 43 set), bit 41 (readable) is set. Any other case gives GP.
- R6: A stack load needs bit 44 set, bit 43 clear, bit 41 (writable) set and DPL equal to the CPL, or it gives GP. A null selector loaded into a stack register gives GP without a fetch.
- R7: Selectors 0 to 3 load into a data register with no fault and no fetch, and any later access through them gives GP.
- R8: When bit 55 is set, the 20-bit limit (bits 51:48 and 15:0) is shifted left by 12 with ones filled in below it (1 gives 0x1FFF, 0 gives 0xFFF). Otherwise the limit is used as it is.
- R9: For an expand-up segment, an access faults when offset+accLen exceeds the limit. The access length is accLen+1 bytes.
- R10: For a data segment with bit 42 set (expand-down), an access faults when the offset is at or below the limit, or when the last byte lies past the top of the 32-bit space.
- R11: A write faults when the cached segment is code or is data with bit 41 clear.
- R12: An access result appears one cycle after accReq. A faulting access reports SS if a stack register was loaded and GP otherwise, and an access before any successful load gives GP. A passing access returns base (bits 63:56 and 39:16) plus offset, wrapped to 32 bits.
- R13: A write that passes raises accMarkAccessed in its result cycle, and nothing else raises it.
- R14: A load that faults leaves the cached segment unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadReq | input | 1 | Start a load; ignored while a load is in progress |
| loadSel | input | 16 | Selector to load |
| loadCpl | input | 2 | Current privilege level |
| loadIsStack | input | 1 | 1 loads a stack register, 0 a data register |
| gdtLimit | input | 16 | Byte limit of the global table |
| ldtLimit | input | 16 | Byte limit of the local table |
| memReq | output | 1 | Descriptor fetch request |
| memTable | output | 1 | Table for the fetch (0 global, 1 local) |
| memOffset | output | 16 | Byte offset of the entry in the table |
| memValid | input | 1 | Descriptor data valid |
| memData | input | 64 | Fetched descriptor |
| loadDone | output | 1 | One-cycle load completion pulse |
| loadOk | output | 1 | Load succeeded |
| loadFault | output | 2 | Load fault code |
| accReq | input | 1 | Access check request |
| accOffset | input | 32 | Access offset |
| accLen | input | 2 | Access length minus one |
| accWrite | input | 1 | 1 for a write |
| accDone | output | 1 | Access result valid |
| accOk | output | 1 | Access allowed |
| accFault | output | 2 | Access fault code |
| accLinear | output | 32 | Linear address of an allowed access |
| accMarkAccessed | output | 1 | Accessed flag write-back strobe |

## Verification
The bench goes after the inclusive edges of each comparison. An entry whose last byte equals the table limit must be fetched, and one entry further must fault. An access whose last byte sits on the limit must pass, while an expand-down access exactly at the limit must fault. A wrong comparison here would either let an access run one byte past its segment or refuse a legal one. A not-present descriptor filled with otherwise-legal bits catches a design that checks type or privilege before presence and reports GP in place of NP or SS. Mixed CPL and requested-level pairs catch a design that compares DPL with only one of them. Reloading a failing descriptor after a good one shows whether a faulting load destroys the cached segment.

// File: rtl/seg_check_pkg.sv
package seg_check_pkg;
  localparam int SEL_W       = 16;
  localparam int TBL_LIM_W   = 16;
  localparam int DESC_W      = 64;
  localparam int ADDR_W      = 32;
  localparam int RAW_LIM_W   = 20;
  localparam int GRAN_SHIFT  = ADDR_W - RAW_LIM_W;
  localparam int ENTRY_SHIFT = 3;
  localparam int IDX_W       = SEL_W - ENTRY_SHIFT;
  localparam int PL_W        = 2;

  typedef enum logic [1:0] {
    FAULT_NONE = 2'd0,
    FAULT_GP   = 2'd1,
    FAULT_NP   = 2'd2,
    FAULT_SS   = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic finishDecode;
    logic finishFetch;
  } ctlStrobes_t;

  typedef struct packed {
    logic              valid;
    logic              isNull;
    logic              isStack;
    logic              expandDown;
    logic              writable;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } segCache_t;
endpackage

// File: rtl/seg_check_ctrl.sv
module seg_check_ctrl
  import seg_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadReq,
  input  logic        needFetch,
  input  logic        memValid,
  output logic        memReq,
  output ctlStrobes_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_FETCH} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (loadReq) begin
          strobes.capture = 1'b1;
          stateNext       = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (needFetch) begin
          stateNext = ST_FETCH;
        end else begin
          strobes.finishDecode = 1'b1;
          stateNext            = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (memValid) begin
          strobes.finishFetch = 1'b1;
          stateNext           = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign memReq = (state == ST_FETCH);
endmodule

// File: rtl/seg_check_dp.sv
module seg_check_dp
  import seg_check_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobes_t          strobes,
  input  logic [SEL_W-1:0]     loadSel,
  input  logic [PL_W-1:0]      loadCpl,
  input  logic                 loadIsStack,
  input  logic [TBL_LIM_W-1:0] gdtLimit,
  input  logic [TBL_LIM_W-1:0] ldtLimit,
  input  logic [DESC_W-1:0]    memData,
  input  logic                 accReq,
  input  logic [ADDR_W-1:0]    accOffset,
  input  logic [LEN_W-1:0]     accLen,
  input  logic                 accWrite,
  output logic                 needFetch,
  output logic                 memTable,
  output logic [TBL_LIM_W-1:0] memOffset,
  output logic                 loadDone,
  output logic                 loadOk,
  output logic [1:0]           loadFault,
  output logic                 accDone,
  output logic                 accOk,
  output logic [1:0]           accFault,
  output logic [ADDR_W-1:0]    accLinear,
  output logic                 accMarkAccessed
);
  // captured request
  logic [SEL_W-1:0] selQ;
  logic [PL_W-1:0]  cplQ;
  logic             stackQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      cplQ   <= '0;
      stackQ <= 1'b0;
    end else if (strobes.capture) begin
      selQ   <= loadSel;
      cplQ   <= loadCpl;
      stackQ <= loadIsStack;
    end
  end

  // selector decode
  logic [PL_W-1:0]      selRpl;
  logic                 selTi;
  logic [IDX_W-1:0]     selIdx;
  logic                 selNull;
  logic [TBL_LIM_W:0]   entryEnd;
  logic [TBL_LIM_W-1:0] tblLimit;
  logic                 inRange;
  logic [1:0]           decodeFault;

  assign selRpl   = selQ[PL_W-1:0];
  assign selTi    = selQ[PL_W];
  assign selIdx   = selQ[SEL_W-1:ENTRY_SHIFT];
  assign selNull  = (selIdx == '0) && !selTi;
  assign entryEnd = {1'b0, selIdx, {ENTRY_SHIFT{1'b1}}};
  assign tblLimit = selTi ? ldtLimit : gdtLimit;
  assign inRange  = (entryEnd <= {1'b0, tblLimit});
  assign needFetch = !selNull && inRange;
  assign memTable  = selTi;
  assign memOffset = {selIdx, {ENTRY_SHIFT{1'b0}}};

  always_comb begin
    if (selNull) decodeFault = stackQ ? FAULT_GP : FAULT_NONE;
    else         decodeFault = FAULT_GP;
  end

  // descriptor verdict
  logic                 dPresent, dIsSeg, dIsCode, dBit42, dBit41, dGran;
  logic [PL_W-1:0]      dDpl;
  logic [RAW_LIM_W-1:0] dRawLim;
  logic [ADDR_W-1:0]    dLimit, dBase;
  logic [PL_W-1:0]      effLevel;
  logic                 dataOk, stackOk;
  logic [1:0]           descFault;
  logic                 unusedDescBits;

  assign dPresent = memData[47];
  assign dDpl     = memData[46:45];
  assign dIsSeg   = memData[44];
  assign dIsCode  = memData[43];
  assign dBit42   = memData[42];
  assign dBit41   = memData[41];
  assign dGran    = memData[55];
  assign dRawLim  = {memData[51:48], memData[15:0]};
  assign dBase    = {memData[63:56], memData[39:16]};
  assign unusedDescBits = ^{memData[54:52], memData[40]};

  assign dLimit   = dGran ? {dRawLim, {GRAN_SHIFT{1'b1}}} : ADDR_W'(dRawLim);
  assign effLevel = (cplQ > selRpl) ? cplQ : selRpl;
  assign dataOk   = dIsSeg && (!dIsCode || dBit41) && (dDpl >= effLevel);
  assign stackOk  = dIsSeg && !dIsCode && dBit41 && (dDpl == cplQ);

  always_comb begin
    if (!dPresent)    descFault = stackQ ? FAULT_SS : FAULT_NP;
    else if (stackQ)  descFault = stackOk ? FAULT_NONE : FAULT_GP;
    else              descFault = dataOk ? FAULT_NONE : FAULT_GP;
  end

  // load result and cache
  segCache_t cacheQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadDone  <= 1'b0;
      loadOk    <= 1'b0;
      loadFault <= FAULT_NONE;
      cacheQ    <= '0;
    end else begin
      loadDone <= strobes.finishDecode || strobes.finishFetch;
      if (strobes.finishDecode) begin
        loadFault <= decodeFault;
        loadOk    <= (decodeFault == FAULT_NONE);
        if (decodeFault == FAULT_NONE) begin
          cacheQ        <= '0;
          cacheQ.valid  <= 1'b1;
          cacheQ.isNull <= 1'b1;
        end
      end else if (strobes.finishFetch) begin
        loadFault <= descFault;
        loadOk    <= (descFault == FAULT_NONE);
        if (descFault == FAULT_NONE) begin
          cacheQ.valid      <= 1'b1;
          cacheQ.isNull     <= 1'b0;
          cacheQ.isStack    <= stackQ;
          cacheQ.expandDown <= !dIsCode && dBit42;
          cacheQ.writable   <= !dIsCode && dBit41;
          cacheQ.base       <= dBase;
          cacheQ.limit      <= dLimit;
        end
      end
    end
  end

  // access check
  logic [ADDR_W:0] accEnd;
  logic            limFault, wrFault, anyFault;
  logic [1:0]      accCode;

  assign accEnd   = {1'b0, accOffset} + {{(ADDR_W + 1 - LEN_W){1'b0}}, accLen};
  assign limFault = cacheQ.expandDown
                  ? ((accOffset <= cacheQ.limit) || accEnd[ADDR_W])
                  : (accEnd > {1'b0, cacheQ.limit});
  assign wrFault  = accWrite && !cacheQ.writable;
  assign anyFault = !cacheQ.valid || cacheQ.isNull || limFault || wrFault;
  assign accCode  = !anyFault ? FAULT_NONE : (cacheQ.isStack ? FAULT_SS : FAULT_GP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accDone         <= 1'b0;
      accOk           <= 1'b0;
      accFault        <= FAULT_NONE;
      accLinear       <= '0;
      accMarkAccessed <= 1'b0;
    end else begin
      accDone         <= accReq;
      accOk           <= accReq && !anyFault;
      accFault        <= accReq ? accCode : FAULT_NONE;
      accMarkAccessed <= accReq && !anyFault && accWrite;
      if (accReq) accLinear <= cacheQ.base + accOffset;
    end
  end
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_check_pkg::*;
#(
  parameter int LEN_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadReq,
  input  logic [SEL_W-1:0]     loadSel,
  input  logic [PL_W-1:0]      loadCpl,
  input  logic                 loadIsStack,
  input  logic [TBL_LIM_W-1:0] gdtLimit,
  input  logic [TBL_LIM_W-1:0] ldtLimit,
  output logic                 memReq,
  output logic                 memTable,
  output logic [TBL_LIM_W-1:0] memOffset,
  input  logic                 memValid,
  input  logic [DESC_W-1:0]    memData,
  output logic                 loadDone,
  output logic                 loadOk,
  output logic [1:0]           loadFault,
  input  logic                 accReq,
  input  logic [ADDR_W-1:0]    accOffset,
  input  logic [LEN_W-1:0]     accLen,
  input  logic                 accWrite,
  output logic                 accDone,
  output logic                 accOk,
  output logic [1:0]           accFault,
  output logic [ADDR_W-1:0]    accLinear,
  output logic                 accMarkAccessed
);
  ctlStrobes_t strobes;
  logic        needFetch;

  seg_check_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadReq   (loadReq),
    .needFetch (needFetch),
    .memValid  (memValid),
    .memReq    (memReq),
    .strobes   (strobes)
  );

  seg_check_dp #(.LEN_W(LEN_W)) u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .loadSel         (loadSel),
    .loadCpl         (loadCpl),
    .loadIsStack     (loadIsStack),
    .gdtLimit        (gdtLimit),
    .ldtLimit        (ldtLimit),
    .memData         (memData),
    .accReq          (accReq),
    .accOffset       (accOffset),
    .accLen          (accLen),
    .accWrite        (accWrite),
    .needFetch       (needFetch),
    .memTable        (memTable),
    .memOffset       (memOffset),
    .loadDone        (loadDone),
    .loadOk          (loadOk),
    .loadFault       (loadFault),
    .accDone         (accDone),
    .accOk           (accOk),
    .accFault        (accFault),
    .accLinear       (accLinear),
    .accMarkAccessed (accMarkAccessed)
  );
endmodule

// File: rtl/seg_check_asserts.sv
module seg_check_asserts (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memValid,
  input logic        memTable,
  input logic [15:0] memOffset,
  input logic        loadDone,
  input logic        loadOk,
  input logic [1:0]  loadFault,
  input logic        accReq,
  input logic        accWrite,
  input logic        accDone,
  input logic        accOk,
  input logic [1:0]  accFault,
  input logic        accMarkAccessed
);
  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> memReq);

  assert_fetch_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> ($stable(memOffset) && $stable(memTable)));

  assert_done_after_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memValid) |=> (loadDone && !memReq));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> !loadDone);

  assert_load_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> (loadOk == (loadFault == 2'd0)));

  assert_acc_latency_R12: assert property (@(posedge clk) disable iff (!rstN)
    accReq |=> accDone);

  assert_acc_code_R12: assert property (@(posedge clk) disable iff (!rstN)
    accDone |-> (accOk == (accFault == 2'd0)));

  assert_mark_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    accMarkAccessed |-> (accDone && accOk && $past(accWrite)));
endmodule

bind seg_load_checker seg_check_asserts u_segCheckAsserts (
  .clk             (clk),
  .rstN            (rstN),
  .memReq          (memReq),
  .memValid        (memValid),
  .memTable        (memTable),
  .memOffset       (memOffset),
  .loadDone        (loadDone),
  .loadOk          (loadOk),
  .loadFault       (loadFault),
  .accReq          (accReq),
  .accWrite        (accWrite),
  .accDone         (accDone),
  .accOk           (accOk),
  .accFault        (accFault),
  .accMarkAccessed (accMarkAccessed)
);

// File: tb/seg_load_checker_bench.sv
module seg_load_checker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadReq = 1'b0;
  logic [15:0] loadSel = '0;
  logic [1:0]  loadCpl = '0;
  logic        loadIsStack = 1'b0;
  logic [15:0] gdtLimit = 16'h003F;
  logic [15:0] ldtLimit = 16'h001F;
  logic        memReq, memTable;
  logic [15:0] memOffset;
  logic        memValid = 1'b0;
  logic [63:0] memData = '0;
  logic        loadDone, loadOk;
  logic [1:0]  loadFault;
  logic        accReq = 1'b0;
  logic [31:0] accOffset = '0;
  logic [1:0]  accLen = '0;
  logic        accWrite = 1'b0;
  logic        accDone, accOk, accMarkAccessed;
  logic [1:0]  accFault;
  logic [31:0] accLinear;

  int nChecks = 0;
  int nFails  = 0;

  // reference cache
  bit          mValid = 0, mNull = 0, mStack = 0, mDown = 0, mWr = 0;
  logic [31:0] mBase = '0;
  longint      mLimit = 0;

  always #5 clk = ~clk;

  seg_load_checker u_seg_load_checker (
    .clk(clk), .rstN(rstN), .loadReq(loadReq), .loadSel(loadSel), .loadCpl(loadCpl),
    .loadIsStack(loadIsStack), .gdtLimit(gdtLimit), .ldtLimit(ldtLimit),
    .memReq(memReq), .memTable(memTable), .memOffset(memOffset),
    .memValid(memValid), .memData(memData), .loadDone(loadDone), .loadOk(loadOk),
    .loadFault(loadFault), .accReq(accReq), .accOffset(accOffset), .accLen(accLen),
    .accWrite(accWrite), .accDone(accDone), .accOk(accOk), .accFault(accFault),
    .accLinear(accLinear), .accMarkAccessed(accMarkAccessed)
  );

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkDesc(input logic [31:0] base, input logic [19:0] lim,
                                         input logic g, input logic p, input logic [1:0] dpl,
                                         input logic s, input logic [3:0] typ);
    logic [63:0] d;
    d = '0;
    d[15:0]  = lim[15:0];
    d[39:16] = base[23:0];
    d[43:40] = typ;
    d[44]    = s;
    d[46:45] = dpl;
    d[47]    = p;
    d[51:48] = lim[19:16];
    d[55]    = g;
    d[63:56] = base[31:24];
    return d;
  endfunction

  // behavioural expectation of a load; updates the reference cache on success
  task automatic refLoad(input logic [15:0] sel, input logic [1:0] cpl, input bit stk,
                         input logic [63:0] d, output bit fetch, output int fault);
    int idx, tbl, rpl, lvl, dpl;
    bit ok;
    idx = int'(sel) / 8;
    rpl = int'(sel) % 4;
    tbl = sel[2] ? int'(ldtLimit) : int'(gdtLimit);
    dpl = int'(d[46:45]);
    lvl = (int'(cpl) > rpl) ? int'(cpl) : rpl;
    fetch = 0;
    if (sel < 4) begin
      fault = stk ? 1 : 0;
      if (!stk) begin mValid = 1; mNull = 1; mStack = 0; mDown = 0; mWr = 0; end
    end else if (idx * 8 + 7 > tbl) begin
      fault = 1;
    end else begin
      fetch = 1;
      if (!d[47]) fault = stk ? 3 : 2;
      else begin
        if (stk) ok = d[44] && !d[43] && d[41] && (dpl == int'(cpl));
        else     ok = d[44] && (!d[43] || d[41]) && (dpl >= lvl);
        fault = ok ? 0 : 1;
        if (ok) begin
          mValid = 1; mNull = 0; mStack = stk;
          mDown  = !d[43] && d[42];
          mWr    = !d[43] && d[41];
          mBase  = {d[63:56], d[39:16]};
          mLimit = d[55] ? longint'({d[51:48], d[15:0]}) * 4096 + 4095
                         : longint'({d[51:48], d[15:0]});
        end
      end
    end
  endtask

  task automatic refAcc(input logic [31:0] off, input logic [1:0] len, input bit wr,
                        output int fault, output logic [31:0] lin, output bit mark);
    longint lastByte;
    bit lf, wf;
    lastByte = longint'(off) + longint'(len);
    if (mDown) lf = (longint'(off) <= mLimit) || (lastByte > 64'hFFFF_FFFF);
    else       lf = lastByte > mLimit;
    wf = wr && !mWr;
    if (!mValid || mNull) fault = 1;
    else if (lf || wf)    fault = mStack ? 3 : 1;
    else                  fault = 0;
    lin  = mBase + off;
    mark = (fault == 0) && wr;
  endtask

  // called just after a falling edge
  task automatic doLoad(input logic [15:0] sel, input logic [1:0] cpl, input bit stk,
                        input logic [63:0] d, input int lat, input string req);
    bit fetch;
    int fault;
    refLoad(sel, cpl, stk, d, fetch, fault);
    loadSel = sel; loadCpl = cpl; loadIsStack = stk; loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    loadSel = 16'hFFFF;
    chkEq(req, "loadDone early", loadDone, 0);
    @(negedge clk);
    chkEq(req, "memReq", memReq, fetch);
    if (fetch) begin
      chkEq(req, "memTable", memTable, sel[2]);
      chkEq(req, "memOffset", memOffset, {sel[15:3], 3'b000});
      chkEq(req, "loadDone during fetch", loadDone, 0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chkEq(req, "memReq held", memReq, 1);
        chkEq(req, "loadDone while waiting", loadDone, 0);
      end
      memValid = 1'b1; memData = d;
      @(negedge clk);
      memValid = 1'b0; memData = '1;
      chkEq(req, "memReq after valid", memReq, 0);
    end
    chkEq(req, "loadDone", loadDone, 1);
    chkEq(req, "loadFault", loadFault, fault);
    chkEq(req, "loadOk", loadOk, fault == 0);
    @(negedge clk);
    chkEq(req, "loadDone pulse end", loadDone, 0);
  endtask

  task automatic doAcc(input logic [31:0] off, input logic [1:0] len, input bit wr, input string req);
    int fault;
    logic [31:0] lin;
    bit mark;
    refAcc(off, len, wr, fault, lin, mark);
    accOffset = off; accLen = len; accWrite = wr; accReq = 1'b1;
    @(negedge clk);
    accReq = 1'b0;
    chkEq(req, "accDone", accDone, 1);
    chkEq(req, "accFault", accFault, fault);
    chkEq(req, "accOk", accOk, fault == 0);
    if (fault == 0) chkEq(req, "accLinear", accLinear, lin);
    chkEq(req, "accMarkAccessed", accMarkAccessed, mark);
  endtask

  logic [63:0] dData, dNp, dDpl2, dStk;

  initial begin
    dData = mkDesc(32'h0010_0000, 20'h00FFF, 0, 1, 2'd0, 1, 4'b0010);
    dNp   = mkDesc(32'hDEAD_BEEF, 20'hFFFFF, 1, 0, 2'd3, 1, 4'b0010);
    dDpl2 = mkDesc(32'h0000_2000, 20'h000FF, 0, 1, 2'd2, 1, 4'b0010);
    dStk  = mkDesc(32'h0000_3000, 20'h000FF, 0, 1, 2'd1, 1, 4'b0010);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chkEq("R3", "reset loadDone", loadDone, 0);
    chkEq("R3", "reset memReq", memReq, 0);
    chkEq("R12", "reset accDone", accDone, 0);
    doAcc(32'h0, 2'd0, 0, "R12 no load");

    // R1 global table entry, then expand-up limits (R9) and write marking (R13)
    doLoad(16'h0010, 2'd0, 0, dData, 0, "R1");
    doAcc(32'h0FFE, 2'd1, 0, "R9 last byte on limit");
    doAcc(32'h0FFE, 2'd2, 0, "R9 one past limit");
    doAcc(32'h0FFD, 2'd3, 0, "R9 four bytes");
    doAcc(32'h0FFF, 2'd0, 1, "R13 write");
    doAcc(32'h0010, 2'd0, 0, "R13 read no mark");

    // R2 table bounds, R1 local table
    doLoad(16'h0040, 2'd0, 0, dData, 0, "R2 past global");
    doLoad(16'h0038, 2'd0, 0, dData, 0, "R2 last global entry");
    doLoad(16'h001C, 2'd0, 0, dData, 0, "R1 local table");
    doLoad(16'h0024, 2'd0, 0, dData, 0, "R2 past local");
    doLoad(16'h0004, 2'd0, 0, dData, 0, "R1 local entry zero");

    // R3 delayed data
    doLoad(16'h0008, 2'd0, 0, dData, 3, "R3");

    // R4 not present, R14 cache kept
    doLoad(16'h0008, 2'd0, 0, dNp, 0, "R4 data");
    doLoad(16'h0008, 2'd0, 1, dNp, 1, "R4 stack");
    doAcc(32'h0FFE, 2'd1, 0, "R14 cache intact");

    // R5 privilege and type for data registers
    doLoad(16'h0008, 2'd3, 0, dDpl2, 0, "R5 cpl high");
    doLoad(16'h000B, 2'd0, 0, dDpl2, 0, "R5 rpl high");
    doAcc(32'h0FFE, 2'd1, 0, "R14 after privilege fault");
    doLoad(16'h000A, 2'd1, 0, dDpl2, 0, "R5 level equal");
    doLoad(16'h0008, 2'd3, 0, mkDesc(32'h0, 20'hFF, 0, 1, 2'd3, 1, 4'b1000), 0, "R5 exec only");
    doLoad(16'h0008, 2'd3, 0, mkDesc(32'h0, 20'hFF, 0, 1, 2'd3, 0, 4'b0010), 0, "R5 system");
    doLoad(16'h0008, 2'd3, 0, mkDesc(32'h0, 20'hFF, 0, 1, 2'd3, 1, 4'b1010), 0, "R5 readable code");

    // R11 writes through code and read-only data
    doAcc(32'h0010, 2'd0, 1, "R11 code write");
    doAcc(32'h0010, 2'd0, 0, "R11 code read");
    doLoad(16'h0008, 2'd0, 0, mkDesc(32'h0, 20'hFF, 0, 1, 2'd0, 1, 4'b0000), 0, "R11 load ro");
    doAcc(32'h0010, 2'd0, 1, "R11 ro write");

    // R6 stack loads, R12 stack fault code
    doLoad(16'h0009, 2'd1, 1, dStk, 0, "R6 good");
    doAcc(32'h0100, 2'd0, 0, "R12 stack over limit");
    doAcc(32'h00FF, 2'd0, 1, "R12 stack ok");
    doLoad(16'h0009, 2'd2, 1, dStk, 0, "R6 dpl differs");
    doLoad(16'h0009, 2'd1, 1, mkDesc(32'h0, 20'hFF, 0, 1, 2'd1, 1, 4'b0000), 0, "R6 read only");
    doLoad(16'h0009, 2'd1, 1, mkDesc(32'h0, 20'hFF, 0, 1, 2'd1, 1, 4'b1010), 0, "R6 code");
    doLoad(16'h0001, 2'd1, 1, dStk, 0, "R6 null");
    doAcc(32'h00FF, 2'd0, 0, "R14 stack kept");

    // R7 null selector
    doLoad(16'h0003, 2'd0, 0, dData, 0, "R7 load");
    doAcc(32'h0, 2'd0, 0, "R7 use");

    // R8 granularity
    doLoad(16'h0010, 2'd0, 0, mkDesc(32'h0, 20'h1, 1, 1, 2'd0, 1, 4'b0010), 0, "R8 lim1");
    doAcc(32'h1FFF, 2'd0, 0, "R8 top byte");
    doAcc(32'h1FFE, 2'd2, 0, "R8 past top");
    doLoad(16'h0010, 2'd0, 0, mkDesc(32'h0, 20'h0, 1, 1, 2'd0, 1, 4'b0010), 0, "R8 lim0");
    doAcc(32'h0FFF, 2'd0, 0, "R8 lim0 top");
    doAcc(32'h1000, 2'd0, 0, "R8 lim0 past");

    // R10 expand-down
    doLoad(16'h0010, 2'd0, 0, mkDesc(32'h1000_0000, 20'h0FFF, 0, 1, 2'd0, 1, 4'b0110), 0, "R10 load");
    doAcc(32'h0FFF, 2'd0, 0, "R10 at limit");
    doAcc(32'h1000, 2'd0, 1, "R10 above limit");
    doAcc(32'hFFFF_FFFE, 2'd1, 0, "R10 top of space");
    doAcc(32'hFFFF_FFFE, 2'd2, 0, "R10 wraps");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule